// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the register side of a serial port. A host reaches it through a byte-wide synchronous read/write port with a 5-bit address. The block holds a transmit queue and a receive queue, the line and divisor settings, and a two-source interrupt controller. It sits between the host bus and a separate frame engine, which shifts bits on the wire and generates the baud clock.

The frame engine has two connections to the block. It takes bytes from the head of the transmit queue through a take strobe. It delivers each received byte through a load strobe, together with parity and framing error flags. The host reaches both queues through one shared data address: a write appends to the transmit queue, and a read removes the oldest received byte.

The receive interrupt source raises only while the receive fill is strictly above a programmable level. That level can never be below half the queue. To see a partly filled receive queue, software writes a one to the flag-set address. This forces the receive flag, so software can poll with a forced interrupt. The transmit source raises whenever the transmit queue has room.

Top module: `sport_csr_unit`

## Requirements
- R1: The following registers read back what was written. Line config (0x03) is 8 bits and drives `line_cfg`. Divisor low (0x08) and high (0x09) drive `baud_div` as {high, low}. Queue config (0x0b) keeps bits [2:0], 3 and 7 and reads 0 in the other bits. Interrupt enable (0x1e) keeps bits [1:0]. Port enable (0x00) keeps bit 0. Control (0x01) keeps bits [1:0].
- R2: Address 0x04 is the data address. A write appends to the transmit queue. `tx_data` shows the oldest byte, and bytes leave in write order. A read returns and removes the oldest received byte. A read of an empty receive queue returns 0x00 and changes nothing.
- R3: Each queue holds 16 bytes. A host write to a full transmit queue is dropped. A receive load into a full queue is dropped and sets the overrun bit, bit 2 of line status (0x02).
- R4: Queue status (0x0a) has these bits: bit 2 is receive empty; bit 3 is receive fill above the level; bit 4 is transmit full; bit 7 is transmit fill at or below 8. All other bits read 0.
- R5: The receive level equals 8 plus queue-config bits [2:0]. The receive flag (interrupt bit 1) is raised in the cycle after the receive fill exceeds that level, but only while the port is enabled. A fill equal to the level does not raise it.
- R6: The transmit flag (interrupt bit 0) is raised in the cycle after the transmit queue is seen not full while the port is enabled.
- R7: Writing a one to a bit of flag-set (0x1d) raises that flag whatever the queue state or port enable. Writing a one to a bit of flag-clear (0x1c) clears that flag, unless the same flag is being raised in the same cycle, in which case it stays raised.
- R8: `irq` is high exactly when some flag is high and its enable bit is set. Interrupt status (0x1f) returns the raw flags in bits [1:0].
- R9: Writing control with bit 2 set empties both queues and clears the three error bits. Bit 2 always reads back as 0.
- R10: `rx_on` is port-enable AND control bit 0, and `tx_on` is port-enable AND control bit 1. While `rx_on` is low, receive loads are ignored. While `tx_on` is low, take strobes are ignored and `tx_valid` is low. While the port is disabled, the queue conditions raise no flags.
- R11: Line status bits 0 and 1 are sticky and set by an accepted receive load that carries a parity error or a framing error. Bit 6 is high while the transmit queue is empty. All other bits read 0.
- R12: After reset, all registers, both queues and the flags are cleared. Line status then reads 0x40, queue status reads 0x84, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| tx_data | output | 8 | Oldest byte of the transmit queue |
| tx_valid | output | 1 | Transmit queue not empty and transmitter on |
| tx_take | input | 1 | Frame engine removes `tx_data` |
| rx_data | input | 8 | Received byte |
| rx_load | input | 1 | Frame engine delivers `rx_data` |
| rx_parity_err | input | 1 | Parity error on this received byte |
| rx_frame_err | input | 1 | Framing error on this received byte |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| line_cfg | output | 8 | Line config register contents |
| baud_div | output | 16 | Baud divisor |

## Verification
The queue assertions assume that a read of the data address and a receive load can meet in the same cycle. They also assume that a soft reset can coincide with traffic on either queue, so flush is given priority over push and pop. The interrupt assertions assume that a bus write hits only one of flag-set and flag-clear per cycle. The raise-versus-clear race therefore arises only between a queue condition and a clear, and the stimulus drives exactly that race on the transmit flag. The stimulus holds every bus access and every engine strobe for exactly one cycle. It steps the receive fill one byte at a time across the level, so each threshold crossing can be observed on its own.

// File: rtl/sport_pkg.sv
package sport_pkg;

  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam int THRW = 3;
  localparam int NIRQ = 2;
  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 1;

  typedef enum logic [AW-1:0] {
    REG_PORT_EN  = 5'h00,
    REG_CTRL     = 5'h01,
    REG_LSTAT    = 5'h02,
    REG_LCFG     = 5'h03,
    REG_DATA     = 5'h04,
    REG_BAUD_LO  = 5'h08,
    REG_BAUD_HI  = 5'h09,
    REG_FSTAT    = 5'h0a,
    REG_FCFG     = 5'h0b,
    REG_FLAG_CLR = 5'h1c,
    REG_FLAG_SET = 5'h1d,
    REG_IEN      = 5'h1e,
    REG_ISTAT    = 5'h1f
  } reg_addr_e;

  // Receive level in bytes: half the queue plus the programmed field.
  function automatic int rx_level(int depth, int thr);
    return depth / 2 + thr;
  endfunction

  function automatic logic [DW-1:0] fifo_status(logic rx_empty, logic rx_over,
                                                logic tx_full, logic tx_low);
    return {tx_low, 2'b00, tx_full, rx_over, rx_empty, 2'b00};
  endfunction

  function automatic logic [DW-1:0] line_status(logic tx_empty, logic ovr,
                                                logic frm, logic par);
    return {1'b0, tx_empty, 3'b000, ovr, frm, par};
  endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end

  // R3: a push into a full queue leaves the fill untouched
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));

  // R2: a pop from an empty queue leaves it empty
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/sport_irq.sv
module sport_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] raise;

  assign raise = set_req | cond;
  assign irq   = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_req) | raise;
  end

  // R7: a raise in the same cycle as a clear wins
  assert_raise_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise) |=> ((flags & $past(raise)) == $past(raise)));

  // R7: a clear with no raise drops the flag
  assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_req & ~raise)) |=> ((flags & $past(clr_req & ~raise)) == '0));

endmodule

// File: rtl/sport_csr_unit.sv
module sport_csr_unit
  import sport_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_take,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_load,
  input  logic          rx_parity_err,
  input  logic          rx_frame_err,
  output logic          rx_on,
  output logic          tx_on,
  output logic [DW-1:0] line_cfg,
  output logic [15:0]   baud_div
);
  localparam int CW = $clog2(DEPTH + 1);

  // configuration state
  logic            port_en, ctl_rx, ctl_tx;
  logic [DW-1:0]   baud_lo, baud_hi;
  logic [THRW-1:0] fcfg_thr;
  logic            fcfg_rxm, fcfg_txm;
  logic [NIRQ-1:0] ien;
  logic            err_par, err_frm, err_ovr;

  // named internal events
  logic            wr, rd, soft_rst;
  logic            tx_push, tx_pop, rx_push, rx_pop;
  logic [DW-1:0]   rx_head;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [CW:0]     rx_lvl;
  logic            rx_over, tx_low;
  logic [NIRQ-1:0] irq_cond, set_req, clr_req, irq_flags;

  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign soft_rst = wr && (bus_addr == REG_CTRL) && bus_wdata[2];
  assign tx_push  = wr && (bus_addr == REG_DATA);
  assign rx_pop   = rd && (bus_addr == REG_DATA);
  assign rx_on    = port_en & ctl_rx;
  assign tx_on    = port_en & ctl_tx;
  assign rx_push  = rx_load & rx_on;
  assign tx_pop   = tx_take & tx_on;
  assign tx_valid = tx_on & ~tx_empty;
  assign baud_div = {baud_hi, baud_lo};

  assign rx_lvl  = (CW+1)'(rx_level(DEPTH, int'(fcfg_thr)));
  assign rx_over = ({1'b0, rx_cnt} > rx_lvl);
  assign tx_low  = (tx_cnt <= CW'(DEPTH / 2));

  assign irq_cond[IRQ_TX] = port_en & ~tx_full;
  assign irq_cond[IRQ_RX] = port_en & rx_over;
  assign set_req = (wr && bus_addr == REG_FLAG_SET) ? bus_wdata[NIRQ-1:0] : '0;
  assign clr_req = (wr && bus_addr == REG_FLAG_CLR) ? bus_wdata[NIRQ-1:0] : '0;

  sport_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(tx_push), .wdata(bus_wdata), .pop(tx_pop), .rdata(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  sport_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(rx_push), .wdata(rx_data), .pop(rx_pop), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  sport_irq #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .cond(irq_cond), .set_req(set_req),
    .clr_req(clr_req), .en(ien), .flags(irq_flags), .irq(irq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en  <= 1'b0;
      ctl_rx   <= 1'b0;
      ctl_tx   <= 1'b0;
      line_cfg <= '0;
      baud_lo  <= '0;
      baud_hi  <= '0;
      fcfg_thr <= '0;
      fcfg_rxm <= 1'b0;
      fcfg_txm <= 1'b0;
      ien      <= '0;
    end else if (wr) begin
      case (bus_addr)
        REG_PORT_EN: port_en <= bus_wdata[0];
        REG_CTRL:    {ctl_tx, ctl_rx} <= bus_wdata[1:0];
        REG_LCFG:    line_cfg <= bus_wdata;
        REG_BAUD_LO: baud_lo <= bus_wdata;
        REG_BAUD_HI: baud_hi <= bus_wdata;
        REG_FCFG: begin
          fcfg_thr <= bus_wdata[THRW-1:0];
          fcfg_rxm <= bus_wdata[3];
          fcfg_txm <= bus_wdata[7];
        end
        REG_IEN:     ien <= bus_wdata[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_par <= 1'b0;
      err_frm <= 1'b0;
      err_ovr <= 1'b0;
    end else if (soft_rst) begin
      err_par <= 1'b0;
      err_frm <= 1'b0;
      err_ovr <= 1'b0;
    end else begin
      if (rx_push && rx_parity_err) err_par <= 1'b1;
      if (rx_push && rx_frame_err)  err_frm <= 1'b1;
      if (rx_push && rx_full)       err_ovr <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_PORT_EN:  bus_rdata = {7'b0, port_en};
      REG_CTRL:     bus_rdata = {6'b0, ctl_tx, ctl_rx};
      REG_LSTAT:    bus_rdata = line_status(tx_empty, err_ovr, err_frm, err_par);
      REG_LCFG:     bus_rdata = line_cfg;
      REG_DATA:     bus_rdata = rx_empty ? '0 : rx_head;
      REG_BAUD_LO:  bus_rdata = baud_lo;
      REG_BAUD_HI:  bus_rdata = baud_hi;
      REG_FSTAT:    bus_rdata = fifo_status(rx_empty, rx_over, tx_full, tx_low);
      REG_FCFG:     bus_rdata = {fcfg_txm, 3'b000, fcfg_rxm, fcfg_thr};
      REG_IEN:      bus_rdata = {{(DW-NIRQ){1'b0}}, ien};
      REG_ISTAT:    bus_rdata = {{(DW-NIRQ){1'b0}}, irq_flags};
      default:      bus_rdata = '0;
    endcase
  end

  // R9: soft reset leaves both queues empty and the errors clear
  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rx_empty && tx_empty && !err_par && !err_frm && !err_ovr));

  // R5: receive fill above the level raises the receive flag
  assert_rx_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rx_over) |=> irq_flags[IRQ_RX]);

  // R6: room in the transmit queue raises the transmit flag
  assert_tx_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !tx_full) |=> irq_flags[IRQ_TX]);

  // R10: a disabled port takes nothing from the frame engine
  assert_port_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !rx_pop && !soft_rst) |=> (rx_cnt == $past(rx_cnt)));

  // R3: a load into a full receive queue records an overrun
  assert_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !soft_rst) |=> err_ovr);

endmodule

// File: tb/test_sport_csr_unit.sv
module test_sport_csr_unit;
  import sport_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;
  logic [DW-1:0] tx_data;
  logic          tx_valid;
  logic          tx_take = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          rx_load = 1'b0, rx_parity_err = 1'b0, rx_frame_err = 1'b0;
  logic          rx_on, tx_on;
  logic [DW-1:0] line_cfg;
  logic [15:0]   baud_div;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sport_csr_unit i_sport_csr_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_data(rx_data), .rx_load(rx_load), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_on(rx_on), .tx_on(tx_on),
    .line_cfg(line_cfg), .baud_div(baud_div));

  typedef struct packed {
    logic          we;
    logic [AW-1:0] a;
    logic [DW-1:0] d;     // write data, or expected read data
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  // R12 reset values, R1 readback, R9 soft bit reads 0, R10 port enable
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 8'h00, 4'd12},
    '{1'b0, 5'h02, 8'h40, 4'd12},
    '{1'b0, 5'h0a, 8'h84, 4'd12},
    '{1'b0, 5'h1f, 8'h00, 4'd12},
    '{1'b0, 5'h1e, 8'h00, 4'd12},
    '{1'b1, 5'h03, 8'h17, 4'd1},
    '{1'b0, 5'h03, 8'h17, 4'd1},
    '{1'b1, 5'h08, 8'h34, 4'd1},
    '{1'b1, 5'h09, 8'h12, 4'd1},
    '{1'b0, 5'h08, 8'h34, 4'd1},
    '{1'b0, 5'h09, 8'h12, 4'd1},
    '{1'b1, 5'h0b, 8'hff, 4'd1},
    '{1'b0, 5'h0b, 8'h8f, 4'd1},
    '{1'b1, 5'h1e, 8'hff, 4'd1},
    '{1'b0, 5'h1e, 8'h03, 4'd1},
    '{1'b1, 5'h01, 8'h07, 4'd9},
    '{1'b0, 5'h01, 8'h03, 4'd9},
    '{1'b1, 5'h00, 8'h01, 4'd10},
    '{1'b0, 5'h00, 8'h01, 4'd1}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    chk(req, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic push(input logic [DW-1:0] d, input logic p, input logic f);
    @(negedge clk);
    rx_load = 1'b1; rx_data = d; rx_parity_err = p; rx_frame_err = f;
    @(negedge clk);
    rx_load = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] expq [$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 irq after reset", {15'b0, irq}, 16'h0000);
    chk("R12 baud_div after reset", baud_div, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].a, VECS[i].d);
      else begin
        rd(VECS[i].a, v);
        chk($sformatf("R%0d vector %0d", VECS[i].req, i), {8'h00, v}, {8'h00, VECS[i].d});
      end
    end
    chk("R1 baud_div", baud_div, 16'h1234);
    chk("R1 line_cfg", {8'h00, line_cfg}, 16'h0017);
    chk("R10 rx_on", {15'b0, rx_on}, 16'h0001);
    chk("R10 tx_on", {15'b0, tx_on}, 16'h0001);

    // R6 transmit flag raised, R8 irq with both enables
    rdchk("R6 status tx flag", 5'h1f, 8'h01);
    chk("R8 irq tx enabled", {15'b0, irq}, 16'h0001);
    wr(5'h1e, 8'h02);
    chk("R8 irq masked", {15'b0, irq}, 16'h0000);
    wr(5'h1d, 8'h02);
    rdchk("R7 forced rx flag", 5'h1f, 8'h03);
    chk("R8 irq forced rx", {15'b0, irq}, 16'h0001);
    wr(5'h1c, 8'h02);
    rdchk("R7 clear rx flag", 5'h1f, 8'h01);
    chk("R8 irq after clear", {15'b0, irq}, 16'h0000);
    wr(5'h1c, 8'h01);
    rdchk("R7 condition beats clear", 5'h1f, 8'h01);

    // R2 R3 R4 transmit queue
    for (int i = 0; i < 16; i++) wr(5'h04, 8'h10 + 8'(i));
    rdchk("R4 tx full status", 5'h0a, 8'h14);
    rdchk("R11 tx not empty", 5'h02, 8'h00);
    wr(5'h04, 8'hee);
    wr(5'h1c, 8'h01);
    rdchk("R6 full queue no tx flag", 5'h1f, 8'h00);
    for (int i = 0; i < 16; i++) begin
      chk("R2 tx_valid", {15'b0, tx_valid}, 16'h0001);
      chk("R2 tx order", {8'h00, tx_data}, {8'h00, 8'h10 + 8'(i)});
      take();
    end
    chk("R3 write to full dropped", {15'b0, tx_valid}, 16'h0000);
    rdchk("R11 tx empty", 5'h02, 8'h40);

    // R5 receive threshold, level 8
    wr(5'h0b, 8'h00);
    for (int i = 0; i < 8; i++) push(8'ha0 + 8'(i), 1'b0, 1'b0);
    idle();
    rdchk("R4 rx at level", 5'h0a, 8'h80);
    rdchk("R5 no rx flag at level", 5'h1f, 8'h01);
    push(8'ha8, 1'b0, 1'b0);
    idle();
    rdchk("R4 rx above level", 5'h0a, 8'h88);
    rdchk("R5 rx flag above level", 5'h1f, 8'h03);
    chk("R8 irq rx", {15'b0, irq}, 16'h0001);
    rdchk("R2 rx oldest", 5'h04, 8'ha0);
    wr(5'h1c, 8'h02);
    rdchk("R5 clear at level", 5'h1f, 8'h01);
    // level 15
    wr(5'h0b, 8'h07);
    for (int i = 0; i < 7; i++) push(8'hb0 + 8'(i), 1'b0, 1'b0);
    idle();
    rdchk("R5 fill 15 at level 15", 5'h0a, 8'h80);
    rdchk("R5 no flag at 15", 5'h1f, 8'h01);
    push(8'hb7, 1'b0, 1'b0);
    idle();
    rdchk("R5 fill 16 over 15", 5'h0a, 8'h88);
    rdchk("R5 flag at 16", 5'h1f, 8'h03);
    push(8'hc0, 1'b0, 1'b0);
    rdchk("R3 overrun", 5'h02, 8'h44);
    for (int i = 1; i < 9; i++) expq.push_back(8'ha0 + 8'(i));
    for (int i = 0; i < 8; i++) expq.push_back(8'hb0 + 8'(i));
    for (int i = 0; i < 16; i++) rdchk("R2 rx order", 5'h04, expq[i]);
    rdchk("R2 empty read zero", 5'h04, 8'h00);
    rdchk("R4 rx empty", 5'h0a, 8'h84);

    // R11 error bits, R9 soft reset
    push(8'h55, 1'b1, 1'b0);
    rdchk("R11 parity err", 5'h02, 8'h45);
    push(8'h66, 1'b0, 1'b1);
    rdchk("R11 frame err", 5'h02, 8'h47);
    wr(5'h04, 8'h01);
    wr(5'h04, 8'h02);
    rdchk("R11 tx busy", 5'h02, 8'h07);
    wr(5'h01, 8'h07);
    rdchk("R9 errors and tx cleared", 5'h02, 8'h40);
    rdchk("R9 rx flushed", 5'h0a, 8'h84);
    rdchk("R9 soft bit reads 0", 5'h01, 8'h03);

    // R10 port disabled
    wr(5'h00, 8'h00);
    chk("R10 rx_on off", {15'b0, rx_on}, 16'h0000);
    chk("R10 tx_on off", {15'b0, tx_on}, 16'h0000);
    push(8'h77, 1'b0, 1'b0);
    rdchk("R10 load ignored", 5'h0a, 8'h84);
    wr(5'h04, 8'h99);
    chk("R10 tx_valid off", {15'b0, tx_valid}, 16'h0000);
    wr(5'h1c, 8'h03);
    rdchk("R10 no condition flags", 5'h1f, 8'h00);
    wr(5'h1d, 8'h02);
    rdchk("R7 forced while disabled", 5'h1f, 8'h02);
    chk("R8 irq forced rx", {15'b0, irq}, 16'h0001);

    // R12 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R12 baud_div", baud_div, 16'h0000);
    chk("R12 line_cfg", {8'h00, line_cfg}, 16'h0000);
    chk("R12 irq", {15'b0, irq}, 16'h0000);
    rdchk("R12 queue status", 5'h0a, 8'h84);
    rdchk("R12 enable reg", 5'h1e, 8'h00);

    finish_run();
  end

endmodule